// File: doc/BRIEF.md
# Capture-compare timer with PWM

A 16-bit timer/counter with one compare output pin and two capture input pins, programmed through a small register port. The count advances on a one-cycle enable pulse taken either from a power-of-two prescaler on the system clock (divide by 2 to 128) or from rising edges of an external clock pin. The external clock pin and both capture pins each pass through a two-flop synchronizer, and edges are detected on the synchronized copies.

In timer mode the counter wraps from 0xFFFF to 0x0000 and raises an overflow flag. Whenever a count step lands on compare value 0, a two-bit action is applied to the output pin: hold, drive low, drive high or toggle. A selected edge on capture pin A or B copies the current count into that channel's capture register and raises its flag. In PWM mode the counter runs from 0 up to compare value 1 and then restarts. The output is at its active level while the count is below compare value 0. The same two-bit action field then selects the polarity, and capture is disabled.

Software starts and stops the counter, clears it, and clears status flags by writing 1 to them. The clock source can only be changed while the counter is stopped.

Top module: `cct_timer`

## Requirements
- R1: Register map (word addresses): 0 control, 1 count (read only), 2 compare 0, 3 compare 1, 4 capture A (read only), 5 capture B (read only), 6 status. Control bits: [0] run, [1] clear, [2] PWM mode, [5:3] clock select, [7:6] capture A edge, [9:8] capture B edge, [11:10] action 0, [13:12] action 1. Status bits: [0] capture A flag, [1] capture B flag, [2] overflow flag. After reset, every register reads 0 and the compare output is 0.
- R2: In timer mode, when a count step makes the count equal to compare 0, action 0 is applied to the output: 00 holds it, 01 drives 0, 10 drives 1, 11 inverts it.
- R3: Clock select codes 0 to 6 advance the count once every 2^(code+1) system clocks. The first step comes 2^(code+1) clocks after the write that sets run. The count never changes by any amount other than 0 or +1, except when it returns to 0.
- R4: Clock select code 7 advances the count once per rising edge of the external clock pin, after a two-flop synchronizer.
- R5: While run is 0, the count holds its value.
- R6: A control write while run is 1 leaves the clock select unchanged. All other control fields are still written.
- R7: Writing 1 to the clear bit sets the count to 0 in the next cycle, which takes priority over a count step. Writing 0 has no effect. The clear bit reads back as 0.
- R8: In timer mode, a step from 0xFFFF gives 0x0000 and sets the overflow flag.
- R9: Edge select codes per capture channel: 00 ignore, 01 rising, 10 falling, 11 both. A qualifying synchronized edge loads the current count into that channel's capture register and sets its flag. Writing 1 to a status bit clears it, and a new event in the same cycle wins.
- R10: In PWM mode no capture register or capture flag changes, whatever the capture pins do.
- R11: In PWM mode the count goes from 0 to compare 1 and then restarts from 0, so the period is compare 1 + 1 steps.
- R12: In PWM mode the output is active while count < compare 0. Action 0 = 10 makes the active level high, 01 makes it low, and 00 or 11 holds the output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for bus_addr (combinational) |
| ext_clk | input | 1 | External count clock, asynchronous |
| cap_a | input | 1 | Capture pin A, asynchronous |
| cap_b | input | 1 | Capture pin B, asynchronous |
| cmp_out | output | 1 | Compare / PWM output pin |

## Verification
The counter is stepped with prescaler codes 0 and 2 and then with the external clock. This tells apart a correct division ratio, a wrong first-step offset, and edge counting on the wrong polarity. Compare 0 is moved ahead of the running count once for each action code, so each of hold, drive 0, drive 1 and toggle produces an output that the others would not. Capture pins are driven with rising-only, falling-only, both-edge and ignore selections, and are then toggled again in PWM mode, which separates correct edge qualification from a capture path that stays enabled. PWM runs with a 10-step period and a 3-step duty under each polarity code, and one full 16-bit wrap exercises the overflow flag and the toggle action at count 0.

// File: rtl/cct_timer.sv
module cct_timer #(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic          ext_clk,
  input  logic          cap_a,
  input  logic          cap_b,
  output logic          cmp_out
);
  localparam int PW = 7;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_CNT  = AW'(1);
  localparam logic [AW-1:0] A_CMP0 = AW'(2);
  localparam logic [AW-1:0] A_CMP1 = AW'(3);
  localparam logic [AW-1:0] A_CAPA = AW'(4);
  localparam logic [AW-1:0] A_CAPB = AW'(5);
  localparam logic [AW-1:0] A_STAT = AW'(6);

  logic          run, pwm;
  logic [2:0]    sel;
  logic [1:0]    ea, eb, act0, act1;
  logic [W-1:0]  cnt, cmp0, cmp1, cap_a_q, cap_b_q;
  logic          fa, fb, fov, out_q;
  logic [2:0]    xs, as_s, bs_s;
  logic [PW-1:0] pre, pmask;

  logic ctrl_w, stat_w, clr;
  assign ctrl_w = bus_we && bus_addr == A_CTRL;
  assign stat_w = bus_we && bus_addr == A_STAT;
  assign clr    = ctrl_w && bus_wdata[1];

  logic x_rise, a_rise, a_fall, b_rise, b_fall;
  assign x_rise = xs[1] & ~xs[2];
  assign a_rise = as_s[1] & ~as_s[2];
  assign a_fall = ~as_s[1] & as_s[2];
  assign b_rise = bs_s[1] & ~bs_s[2];
  assign b_fall = ~bs_s[1] & bs_s[2];

  assign pmask = PW'((8'd2 << sel) - 8'd1);

  logic tick;
  assign tick = run && ((sel == 3'd7) ? x_rise : ((pre & pmask) == pmask));

  logic [W-1:0] cnt_inc;
  logic period_end, ovf_evt, match_evt, cap_a_evt, cap_b_evt;
  assign cnt_inc    = cnt + W'(1);
  assign period_end = pwm && cnt == cmp1;
  assign ovf_evt    = tick && !pwm && !clr && cnt == '1;
  assign match_evt  = tick && !pwm && !clr && cnt_inc == cmp0;
  assign cap_a_evt  = !pwm && ((ea[0] && a_rise) || (ea[1] && a_fall));
  assign cap_b_evt  = !pwm && ((eb[0] && b_rise) || (eb[1] && b_fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      pwm  <= 1'b0;
      sel  <= '0;
      ea   <= '0;
      eb   <= '0;
      act0 <= '0;
      act1 <= '0;
    end else if (ctrl_w) begin
      run  <= bus_wdata[0];
      pwm  <= bus_wdata[2];
      ea   <= bus_wdata[7:6];
      eb   <= bus_wdata[9:8];
      act0 <= bus_wdata[11:10];
      act1 <= bus_wdata[13:12];
      if (!run) sel <= bus_wdata[5:3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp0 <= '0;
      cmp1 <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_CMP0) cmp0 <= bus_wdata;
      if (bus_addr == A_CMP1) cmp1 <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xs   <= '0;
      as_s <= '0;
      bs_s <= '0;
      pre  <= '0;
    end else begin
      xs   <= {xs[1:0], ext_clk};
      as_s <= {as_s[1:0], cap_a};
      bs_s <= {bs_s[1:0], cap_b};
      pre  <= run ? pre + PW'(1) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (clr) cnt <= '0;
    else if (tick) cnt <= period_end ? '0 : cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else if (match_evt) begin
      case (act0)
        2'b01:   out_q <= 1'b0;
        2'b10:   out_q <= 1'b1;
        2'b11:   out_q <= ~out_q;
        default: out_q <= out_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a_q <= '0;
      cap_b_q <= '0;
      fa      <= 1'b0;
      fb      <= 1'b0;
      fov     <= 1'b0;
    end else begin
      if (cap_a_evt) cap_a_q <= cnt;
      if (cap_b_evt) cap_b_q <= cnt;
      fa  <= (fa  & ~(stat_w & bus_wdata[0])) | cap_a_evt;
      fb  <= (fb  & ~(stat_w & bus_wdata[1])) | cap_b_evt;
      fov <= (fov & ~(stat_w & bus_wdata[2])) | ovf_evt;
    end
  end

  logic pwm_on, pwm_lvl;
  assign pwm_on  = cnt < cmp0;
  assign pwm_lvl = (act0 == 2'b10) ? pwm_on : (act0 == 2'b01) ? ~pwm_on : 1'b0;
  assign cmp_out = pwm ? pwm_lvl : out_q;

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = W'({act1, act0, eb, ea, sel, pwm, 1'b0, run});
      A_CNT:   bus_rdata = cnt;
      A_CMP0:  bus_rdata = cmp0;
      A_CMP1:  bus_rdata = cmp1;
      A_CAPA:  bus_rdata = cap_a_q;
      A_CAPB:  bus_rdata = cap_b_q;
      A_STAT:  bus_rdata = W'({fov, fb, fa});
      default: bus_rdata = '0;
    endcase
  end
endmodule

module cct_timer_chk #(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          wr_clr_bit,
  input logic          run,
  input logic          pwm,
  input logic [2:0]    sel,
  input logic [1:0]    act0,
  input logic [W-1:0]  cnt,
  input logic [W-1:0]  cap_a_q,
  input logic [W-1:0]  cap_b_q,
  input logic          fov,
  input logic          cmp_out
);
  logic clr_w;
  assign clr_w = bus_we && bus_addr == AW'(0) && wr_clr_bit;

  a_r5_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !clr_w |=> $stable(cnt));

  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> cnt == '0);

  a_r6_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(sel));

  a_r10_pwm_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    pwm |=> $stable(cap_a_q) && $stable(cap_b_q));

  a_r12_invalid_pol_low: assert property (@(posedge clk) disable iff (!rst_n)
    pwm && (act0 == 2'b00 || act0 == 2'b11) |-> !cmp_out);

  a_r8_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm && !clr_w && cnt == '1 |=> cnt == '1 || fov);

  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_w |=> cnt == $past(cnt) || cnt == $past(cnt) + W'(1) || cnt == '0);
endmodule

bind cct_timer cct_timer_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .wr_clr_bit(bus_wdata[1]), .run(run), .pwm(pwm), .sel(sel), .act0(act0),
  .cnt(cnt), .cap_a_q(cap_a_q), .cap_b_q(cap_b_q), .fov(fov), .cmp_out(cmp_out)
);

// File: tb/cct_timer_tb_top.sv
`timescale 1ns/1ps
module cct_timer_tb_top;
  logic clk = 0, rst_n = 0;
  logic bus_we = 0;
  logic [2:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic ext_clk = 0, cap_a = 0, cap_b = 0, cmp_out;

  always #10 clk = ~clk;

  cct_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk),
    .cap_a(cap_a), .cap_b(cap_b), .cmp_out(cmp_out)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // behavioural reference
  bit m_run, m_pwm, m_outq, m_fa, m_fb, m_fov;
  int m_sel, m_ea, m_eb, m_a0, m_a1, m_phase;
  int m_cnt, m_cmp0, m_cmp1, m_capa, m_capb;
  bit mx[3], ma[3], mb[3];

  function automatic bit m_out();
    bit on;
    on = m_cnt < m_cmp0;
    if (!m_pwm) return m_outq;
    if (m_a0 == 2) return on;
    if (m_a0 == 1) return !on;
    return 0;
  endfunction

  function automatic int m_reg(int a);
    case (a)
      0: return m_run + m_pwm * 4 + m_sel * 8 + m_ea * 64 + m_eb * 256 + m_a0 * 1024 + m_a1 * 4096;
      1: return m_cnt;
      2: return m_cmp0;
      3: return m_cmp1;
      4: return m_capa;
      5: return m_capb;
      6: return m_fa + m_fb * 2 + m_fov * 4;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_pwm = 0; m_outq = 0; m_fa = 0; m_fb = 0; m_fov = 0;
      m_sel = 0; m_ea = 0; m_eb = 0; m_a0 = 0; m_a1 = 0; m_phase = 0;
      m_cnt = 0; m_cmp0 = 0; m_cmp1 = 0; m_capa = 0; m_capb = 0;
      for (int i = 0; i < 3; i++) begin mx[i] = 0; ma[i] = 0; mb[i] = 0; end
    end else begin
      int div, ncnt;
      bit tk, clr, ev_a, ev_b, ev_ov, ar, af, br, bf;
      div = 2 << m_sel;
      tk  = m_run && ((m_sel == 7) ? (mx[1] && !mx[2]) : ((m_phase % div) == div - 1));
      clr = bus_we && bus_addr == 0 && bus_wdata[1];
      ar = ma[1] && !ma[2]; af = !ma[1] && ma[2];
      br = mb[1] && !mb[2]; bf = !mb[1] && mb[2];
      ev_a = !m_pwm && (((m_ea & 1) && ar) || ((m_ea & 2) && af));
      ev_b = !m_pwm && (((m_eb & 1) && br) || ((m_eb & 2) && bf));
      ev_ov = 0;
      ncnt = m_cnt;
      if (clr) ncnt = 0;
      else if (tk) begin
        if (m_pwm) ncnt = (m_cnt == m_cmp1) ? 0 : m_cnt + 1;
        else begin
          ncnt = (m_cnt + 1) % 65536;
          ev_ov = (m_cnt == 65535);
          if (ncnt == m_cmp0) begin
            if (m_a0 == 1) m_outq = 0;
            else if (m_a0 == 2) m_outq = 1;
            else if (m_a0 == 3) m_outq = !m_outq;
          end
        end
      end
      if (ev_a) m_capa = m_cnt;
      if (ev_b) m_capb = m_cnt;
      if (bus_we && bus_addr == 6) begin
        if (bus_wdata[0]) m_fa = 0;
        if (bus_wdata[1]) m_fb = 0;
        if (bus_wdata[2]) m_fov = 0;
      end
      if (ev_a) m_fa = 1;
      if (ev_b) m_fb = 1;
      if (ev_ov) m_fov = 1;
      m_phase = m_run ? m_phase + 1 : 0;
      if (bus_we && bus_addr == 2) m_cmp0 = bus_wdata;
      if (bus_we && bus_addr == 3) m_cmp1 = bus_wdata;
      if (bus_we && bus_addr == 0) begin
        if (!m_run) m_sel = bus_wdata[5:3];
        m_run = bus_wdata[0]; m_pwm = bus_wdata[2];
        m_ea = bus_wdata[7:6]; m_eb = bus_wdata[9:8];
        m_a0 = bus_wdata[11:10]; m_a1 = bus_wdata[13:12];
      end
      mx[2] = mx[1]; mx[1] = mx[0]; mx[0] = ext_clk;
      ma[2] = ma[1]; ma[1] = ma[0]; ma[0] = cap_a;
      mb[2] = mb[1]; mb[1] = mb[0]; mb[0] = cap_b;
      m_cnt = ncnt;
    end
  end

  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      total++;
      if (cmp_out !== m_out()) begin
        bad++;
        $display("FAIL R2/R12 cmp_out actual=%0b expected=%0b t=%0t", cmp_out, m_out(), $time);
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_we = 1; bus_addr = a[2:0]; bus_wdata = d[15:0];
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd_now(input int a, output int v);
    bus_addr = a[2:0];
    #2;
    v = bus_rdata;
  endtask

  task automatic rd_model(input int a, input string tag);
    int v;
    @(negedge clk);
    rd_now(a, v);
    chk(v, m_reg(a), tag);
  endtask

  function automatic int ctl(int run, int clr, int pwm, int sel, int ea, int eb, int a0, int a1);
    return run + clr * 2 + pwm * 4 + sel * 8 + ea * 64 + eb * 256 + a0 * 1024 + a1 * 4096;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    repeat (n) begin
      @(posedge clk); #5;
      if (cmp_out) hi++;
    end
  endtask

  initial begin
    #(20 * 180000);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, v2, hi;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      @(negedge clk); rd_now(a, v); chk(v, 0, "R1 reset register");
    end
    chk(cmp_out, 0, "R1 reset output");

    // R3 divide by 2
    wr(2, 16'hFFFF);
    wr(0, ctl(1, 1, 0, 0, 0, 0, 0, 0));
    wait_cyc(32); rd_now(1, v); chk(v, 16, "R3 div2 count after 32 clocks");
    // R3 divide by 8 (stop, reselect, restart)
    wr(0, ctl(0, 0, 0, 0, 0, 0, 0, 0));
    wr(0, ctl(1, 1, 0, 2, 0, 0, 0, 0));
    wait_cyc(32); rd_now(1, v); chk(v, 4, "R3 div8 count after 32 clocks");
    // R6 select locked while running
    wr(0, ctl(1, 0, 0, 0, 0, 0, 0, 0));
    @(negedge clk); rd_now(0, v); chk((v >> 3) & 7, 2, "R6 select kept while running");
    wait_cyc(16); rd_model(1, "R6 count rate unchanged");
    // R7 clear
    wr(0, ctl(1, 1, 0, 0, 0, 0, 0, 0));
    rd_now(1, v); chk(v, 0, "R7 clear zeroes count");
    rd_now(0, v); chk((v >> 1) & 1, 0, "R7 clear bit reads 0");
    wait_cyc(24);
    wr(0, ctl(1, 0, 0, 0, 0, 0, 0, 0));
    rd_now(1, v); chk(v != 0, 1, "R7 clear=0 has no effect");
    rd_model(1, "R7 count after no-op write");
    // R5 stop holds
    wr(0, ctl(0, 0, 0, 2, 0, 0, 0, 0));
    rd_now(1, v); wait_cyc(20); rd_now(1, v2);
    chk(v2, v, "R5 count held while stopped");

    // R2 compare actions, div2
    wr(2, 6);
    wr(0, ctl(0, 1, 0, 0, 0, 0, 0, 0));
    wr(0, ctl(1, 0, 0, 0, 0, 0, 2, 2));
    wait_cyc(30); chk(cmp_out, 1, "R2 action 10 drives 1");
    wr(2, 40); wr(0, ctl(1, 0, 0, 0, 0, 0, 1, 1));
    wait_cyc(70); chk(cmp_out, 0, "R2 action 01 drives 0");
    wr(2, 80); wr(0, ctl(1, 0, 0, 0, 0, 0, 3, 3));
    wait_cyc(70); chk(cmp_out, 1, "R2 action 11 toggles");
    wr(2, 120); wr(0, ctl(1, 0, 0, 0, 0, 0, 0, 0));
    wait_cyc(70); chk(cmp_out, 1, "R2 action 00 holds");
    rd_model(1, "R2 count");

    // R4 external clock
    wr(0, ctl(0, 0, 0, 0, 0, 0, 0, 0));
    wr(0, ctl(1, 1, 0, 7, 0, 0, 0, 0));
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); ext_clk = 1; wait_cyc(3); ext_clk = 0; wait_cyc(3);
    end
    wait_cyc(4); rd_now(1, v); chk(v, 5, "R4 one step per external rising edge");
    wr(0, ctl(0, 0, 0, 7, 0, 0, 0, 0));

    // R9 capture
    wr(0, ctl(1, 1, 0, 0, 1, 2, 0, 0));
    wait_cyc(10); cap_a = 1; cap_b = 1; wait_cyc(8);
    rd_model(4, "R9 capture A on rising");
    rd_now(6, v); chk(v & 3, 1, "R9 only A flag after rising edges");
    chk(m_capa != 0, 1, "R9 capture A loaded nonzero count");
    wait_cyc(6); cap_a = 0; cap_b = 0; wait_cyc(8);
    rd_model(5, "R9 capture B on falling");
    rd_now(6, v); chk(v & 3, 3, "R9 both flags set");
    rd_now(4, v2); chk(v2, m_capa, "R9 rising-only ignores falling A");
    wr(6, 1);
    rd_now(6, v); chk(v & 3, 2, "R9 write-1 clears A flag only");
    wr(0, ctl(1, 0, 0, 0, 3, 0, 0, 0));
    wait_cyc(5); cap_a = 1; wait_cyc(8); cap_a = 0; wait_cyc(8);
    rd_model(4, "R9 both-edge capture A");
    rd_now(6, v); chk(v & 1, 1, "R9 both-edge sets flag");
    rd_now(4, v); wr(0, ctl(1, 0, 0, 0, 0, 0, 0, 0));
    cap_a = 1; wait_cyc(8); cap_a = 0; wait_cyc(8);
    rd_now(4, v2); chk(v2, v, "R9 edge code 00 ignores pin");

    // R11/R12 PWM
    wr(6, 7);
    wr(0, ctl(0, 0, 0, 0, 0, 0, 0, 0));
    wr(3, 9); wr(2, 3);
    wr(0, ctl(1, 1, 1, 0, 0, 0, 2, 2));
    v = 0;
    repeat (30) begin @(negedge clk); rd_now(1, v2); if (v2 > v) v = v2; end
    chk(v, 9, "R11 count peaks at compare 1");
    count_high(40, hi); chk(hi, 12, "R12 active-high duty 6 of 20");
    wr(0, ctl(1, 0, 1, 0, 0, 0, 1, 1));
    count_high(40, hi); chk(hi, 28, "R12 active-low duty");
    wr(0, ctl(1, 0, 1, 0, 0, 0, 0, 0));
    count_high(40, hi); chk(hi, 0, "R12 invalid code holds 0");
    // R10 capture off in PWM
    wr(0, ctl(1, 0, 1, 0, 3, 3, 2, 2));
    rd_now(4, v); rd_now(5, v2);
    cap_a = 1; cap_b = 1; wait_cyc(8); cap_a = 0; cap_b = 0; wait_cyc(8);
    rd_now(4, hi); chk(hi, v, "R10 capture A frozen in PWM");
    rd_now(5, hi); chk(hi, v2, "R10 capture B frozen in PWM");
    rd_now(6, hi); chk(hi, 0, "R10 no flags in PWM");

    // R8 full wrap with toggle at 0
    wr(0, ctl(0, 0, 0, 0, 0, 0, 0, 0));
    wr(2, 0);
    wr(0, ctl(1, 1, 0, 0, 0, 0, 3, 3));
    wait_cyc(131076);
    rd_now(6, v); chk((v >> 2) & 1, 1, "R8 overflow flag after wrap");
    rd_model(1, "R8 count after wrap");
    wr(6, 4);
    rd_now(6, v); chk((v >> 2) & 1, 0, "R8 overflow flag cleared");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule